// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences a chip into stop and very-low-leakage states and brings it back out. Software reaches it through four byte-wide registers. It writes a one-time protection mask that permits the deeper states. It then picks a target mode and a leakage sub-level. Once that is set up, a pulse on `sleep_req` starts the entry sequence.

On entry the core clock is gated in the next cycle. The block then waits, with no time limit, until every peripheral stop-acknowledge input is high. Only then are the clocks to the other masters and the bus gated. In very-low-leakage mode the internal-logic and auxiliary-RAM power-down outputs are asserted at the same moment, together with I/O hold. System RAM partitions are powered down according to the sub-level. A single `wake` input reverses the sequence over two cycles, and a status register follows each step as a one-hot code.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset, the registers read 00h (offset 0, protection), 00h (offset 1, control), 03h (offset 2, sub-level) and 01h (offset 3, status), and all gating and power outputs are low. Read data appears on `reg_rdata` one cycle after `reg_addr` is presented.
- R2: The first write to offset 0 after reset stores the whole byte. Every later write to offset 0 leaves it unchanged until the next reset.
- R3: Control bits [1:0] select the mode: 00 run, 01 stop, 10 very-low-leakage. Bits [7:2] are discarded and read 0. A write of 01 takes effect only when protection bit 0 is set, and a write of 10 only when protection bit 1 is set. A write of 11 and any write that is not permitted leave the stored mode unchanged. A write of 00 is always accepted.
- R4: Sub-level bits [1:0] accept the values 1, 2 and 3. A write of 0 leaves the stored level unchanged.
- R5: A `sleep_req` pulse while the mode is run changes no output, and status stays 01h.
- R6: A `sleep_req` pulse while the mode is stop or very-low-leakage raises `core_clk_gate` one cycle later, and status reads 02h.
- R7: `sys_clk_gate` rises only in the cycle after every bit of `stop_ack` is high. While any bit is low, the block waits indefinitely with only the core clock gated.
- R8: At sub-level 3, very-low-leakage entry asserts `logic_pwr_off`, `aux_ram_off` and `io_hold` together with `sys_clk_gate`. Both RAM partitions stay powered and status reads 04h.
- R9: At sub-level 2, very-low-leakage entry additionally powers down RAM partition 2 (`ram_pwr_off[1]`) and keeps partition 1 powered.
- R10: At sub-level 1, very-low-leakage entry powers down both RAM partitions (`ram_pwr_off` = 11).
- R11: In stop mode, the acknowledge completes with both clocks gated and no power-down or hold output asserted, and status stays 02h.
- R12: A `wake` pulse in the gated state clears `sys_clk_gate` and all power and hold outputs one cycle later, with status 02h. One cycle after that, `core_clk_gate` clears and status reads 01h.
- R13: A `wake` pulse while still waiting for acknowledges clears `core_clk_gate` one cycle later and returns status to 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sleep_req | input | 1 | Pulse that starts low-power entry |
| wake | input | 1 | Wake-up event |
| stop_ack | input | N_ACK (4) | Per-peripheral stop acknowledge |
| core_clk_gate | output | 1 | High gates the core clock |
| sys_clk_gate | output | 1 | High gates master and bus clocks |
| logic_pwr_off | output | 1 | Internal logic power-down |
| aux_ram_off | output | 1 | Auxiliary RAM power-down |
| ram_pwr_off | output | N_RAM (2) | Bit i powers down RAM partition i+1 |
| io_hold | output | 1 | Hold I/O states |

## Verification
Some internal faults are visible at once. A wrongly latched mode or sub-level, or a sequencer state that skipped the acknowledge wait, shows on the gate and power pins in the first cycle after `sleep_req`, after the last acknowledge or after `wake`. The bench compares all seven control outputs as one vector at each of those cycles. A broken lock flag or mode filter is different: it changes nothing on the control pins until a later read or entry. The bench therefore reads the registers back right after each rejected write, and the status register at every step of the sequence.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int REG_DATA_W = 8;
  localparam int STAT_W     = 3;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_STOP = 2'b01,
    MODE_VLL  = 2'b10
  } lp_mode_e;

  typedef enum logic [1:0] {
    SQ_RUN,
    SQ_WAIT_ACK,
    SQ_GATED,
    SQ_WAKE
  } lp_state_e;

  localparam logic [STAT_W-1:0] STAT_RUN  = 3'b001;
  localparam logic [STAT_W-1:0] STAT_STOP = 3'b010;
  localparam logic [STAT_W-1:0] STAT_VLL  = 3'b100;
endpackage

// File: rtl/lp_regs.sv
module lp_regs
  import lp_pkg::*;
#(
  parameter int N_RAM = 2,
  localparam int LVL_W = $clog2(N_RAM + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr,
  input  logic [REG_DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0]     status,
  output logic [REG_DATA_W-1:0] rdata,
  output lp_mode_e              mode,
  output logic [LVL_W-1:0]      level
);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(N_RAM + 1);

  logic [REG_DATA_W-1:0] prot_q;
  logic                  prot_locked;
  logic [1:0]            mode_wr;
  logic [LVL_W-1:0]      lvl_wr;
  logic                  mode_ok;
  logic [REG_DATA_W-1:0] rd_next;

  assign mode_wr = wdata[1:0];
  assign lvl_wr  = wdata[LVL_W-1:0];

  always_comb begin
    unique case (mode_wr)
      MODE_RUN:  mode_ok = 1'b1;
      MODE_STOP: mode_ok = prot_q[0];
      MODE_VLL:  mode_ok = prot_q[1];
      default:   mode_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q      <= '0;
      prot_locked <= 1'b0;
      mode        <= MODE_RUN;
      level       <= LVL_TOP;
    end else if (wr) begin
      case (addr)
        2'd0: if (!prot_locked) begin
          prot_q      <= wdata;
          prot_locked <= 1'b1;
        end
        2'd1: if (mode_ok) mode <= lp_mode_e'(mode_wr);
        2'd2: if (lvl_wr != '0 && lvl_wr <= LVL_TOP) level <= lvl_wr;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      2'd0:    rd_next = prot_q;
      2'd1:    rd_next[1:0] = mode;
      2'd2:    rd_next[LVL_W-1:0] = level;
      default: rd_next[STAT_W-1:0] = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assert_prot_once_R2: assert property (@(posedge clk) disable iff (rst)
    (prot_locked && wr && addr == 2'd0) |=> $stable(prot_q));

  // R3: a very-low-leakage request without permission keeps the mode
  assert_mode_guard_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd1 && mode_wr == 2'b10 && !prot_q[1]) |=> $stable(mode));

  assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    level != '0);
endmodule

// File: rtl/lp_pwr_map.sv
module lp_pwr_map #(
  parameter int N_RAM = 2,
  localparam int LVL_W = $clog2(N_RAM + 2)
) (
  input  logic [LVL_W-1:0] level,
  output logic [N_RAM-1:0] ram_off
);
  // Partition p (1-based) loses power at every level not above p.
  for (genvar i = 0; i < N_RAM; i++) begin : g_part
    assign ram_off[i] = (level <= LVL_W'(i + 1));
  end
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
#(
  parameter int N_ACK = 4,
  parameter int N_RAM = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              wake,
  input  logic [N_ACK-1:0]  stop_ack,
  input  lp_mode_e          mode,
  input  logic [N_RAM-1:0]  ram_off_sel,
  output logic              core_gate,
  output logic              sys_gate,
  output logic              logic_off,
  output logic              aux_off,
  output logic [N_RAM-1:0]  ram_off,
  output logic              io_hold,
  output logic [STAT_W-1:0] status
);
  lp_state_e state;
  logic      tgt_vll;
  logic      all_ack;

  assign all_ack = &stop_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_RUN;
      tgt_vll   <= 1'b0;
      core_gate <= 1'b0;
      sys_gate  <= 1'b0;
      logic_off <= 1'b0;
      aux_off   <= 1'b0;
      ram_off   <= '0;
      io_hold   <= 1'b0;
      status    <= STAT_RUN;
    end else begin
      case (state)
        SQ_RUN: if (sleep_req && mode != MODE_RUN) begin
          state     <= SQ_WAIT_ACK;
          tgt_vll   <= (mode == MODE_VLL);
          core_gate <= 1'b1;
          status    <= STAT_STOP;
        end
        SQ_WAIT_ACK: if (wake) begin
          state     <= SQ_RUN;
          core_gate <= 1'b0;
          status    <= STAT_RUN;
        end else if (all_ack) begin
          state    <= SQ_GATED;
          sys_gate <= 1'b1;
          if (tgt_vll) begin
            logic_off <= 1'b1;
            aux_off   <= 1'b1;
            ram_off   <= ram_off_sel;
            io_hold   <= 1'b1;
            status    <= STAT_VLL;
          end
        end
        SQ_GATED: if (wake) begin
          state     <= SQ_WAKE;
          sys_gate  <= 1'b0;
          logic_off <= 1'b0;
          aux_off   <= 1'b0;
          ram_off   <= '0;
          io_hold   <= 1'b0;
          status    <= STAT_STOP;
        end
        default: begin
          state     <= SQ_RUN;
          core_gate <= 1'b0;
          status    <= STAT_RUN;
        end
      endcase
    end
  end

  assert_core_before_sys_R6: assert property (@(posedge clk) disable iff (rst)
    sys_gate |-> core_gate);

  assert_ack_before_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_gate) |-> $past(all_ack));

  assert_pd_needs_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (logic_off || aux_off || io_hold || (|ram_off)) |-> sys_gate);

  assert_status_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $countones(status) == 1);

  for (genvar i = 1; i < N_RAM; i++) begin : g_order
    // R10: a lower partition never loses power while a higher one keeps it
    assert_ram_order_R10: assert property (@(posedge clk) disable iff (rst)
      ram_off[i-1] |-> ram_off[i]);
  end
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_pkg::*;
#(
  parameter int N_ACK = 4,
  parameter int N_RAM = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  input  logic                  sleep_req,
  input  logic                  wake,
  input  logic [N_ACK-1:0]      stop_ack,
  output logic                  core_clk_gate,
  output logic                  sys_clk_gate,
  output logic                  logic_pwr_off,
  output logic                  aux_ram_off,
  output logic [N_RAM-1:0]      ram_pwr_off,
  output logic                  io_hold
);
  localparam int LVL_W = $clog2(N_RAM + 2);

  lp_mode_e          mode;
  logic [LVL_W-1:0]  level;
  logic [N_RAM-1:0]  ram_sel;
  logic [STAT_W-1:0] status;

  lp_regs #(.N_RAM(N_RAM)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .status(status), .rdata(reg_rdata), .mode(mode), .level(level)
  );

  lp_pwr_map #(.N_RAM(N_RAM)) u_map (
    .level(level), .ram_off(ram_sel)
  );

  lp_fsm #(.N_ACK(N_ACK), .N_RAM(N_RAM)) u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake(wake),
    .stop_ack(stop_ack), .mode(mode), .ram_off_sel(ram_sel),
    .core_gate(core_clk_gate), .sys_gate(sys_clk_gate),
    .logic_off(logic_pwr_off), .aux_off(aux_ram_off),
    .ram_off(ram_pwr_off), .io_hold(io_hold), .status(status)
  );
endmodule

// File: tb/test_lp_mode_seq.sv
module test_lp_mode_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sleep_req = 1'b0;
  logic       wake = 1'b0;
  logic [3:0] stop_ack = '0;
  logic       core_clk_gate, sys_clk_gate, logic_pwr_off, aux_ram_off, io_hold;
  logic [1:0] ram_pwr_off;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  lp_mode_seq i_lp_mode_seq (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .wake(wake), .stop_ack(stop_ack), .core_clk_gate(core_clk_gate),
    .sys_clk_gate(sys_clk_gate), .logic_pwr_off(logic_pwr_off),
    .aux_ram_off(aux_ram_off), .ram_pwr_off(ram_pwr_off), .io_hold(io_hold)
  );

  // {core, sys, logic, aux, ram2, ram1, io}
  localparam logic [6:0] O_RUN  = 7'b0000000;
  localparam logic [6:0] O_WAIT = 7'b1000000;
  localparam logic [6:0] O_STOP = 7'b1100000;
  localparam logic [6:0] O_V3   = 7'b1111001;
  localparam logic [6:0] O_V2   = 7'b1111101;
  localparam logic [6:0] O_V1   = 7'b1111111;

  function automatic logic [6:0] outs();
    return {core_clk_gate, sys_clk_gate, logic_pwr_off, aux_ram_off,
            ram_pwr_off, io_hold};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; reg_wr = 1'b0; sleep_req = 1'b0; wake = 1'b0; stop_ack = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_sleep();
    @(negedge clk);
    sleep_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 outputs", {1'b0, outs()}, {1'b0, O_RUN});
    rd(2'd0, d); check("R1 prot", d, 8'h00);
    rd(2'd1, d); check("R1 ctrl", d, 8'h00);
    rd(2'd2, d); check("R1 level", d, 8'h03);
    rd(2'd3, d); check("R1 status", d, 8'h01);
  endtask

  task automatic t_prot_once();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R2 first write", d, 8'h01);
    wr(2'd0, 8'hA3);
    rd(2'd0, d); check("R2 second write ignored", d, 8'h01);
    wr(2'd1, 8'h02);
    rd(2'd1, d); check("R2 vll still blocked", d, 8'h00);
  endtask

  task automatic t_ctrl_guard();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    rd(2'd1, d); check("R3 stop not permitted", d, 8'h00);
    wr(2'd1, 8'hF2);
    rd(2'd1, d); check("R3 vll permitted, upper bits dropped", d, 8'h02);
    wr(2'd1, 8'h03);
    rd(2'd1, d); check("R3 code 11 ignored", d, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R3 run accepted", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    do_reset();
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R4 zero ignored", d, 8'h03);
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R4 level 1", d, 8'h01);
    wr(2'd2, 8'h02);
    rd(2'd2, d); check("R4 level 2", d, 8'h02);
  endtask

  task automatic t_run_sleep();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h03);
    stop_ack = 4'hF;
    pulse_sleep();
    check("R5 outputs unchanged", {1'b0, outs()}, {1'b0, O_RUN});
    rd(2'd3, d); check("R5 status run", d, 8'h01);
    stop_ack = '0;
  endtask

  // Enters a mode, waits on partial acks, completes, then wakes.
  task automatic t_cycle(input string req, input logic [7:0] mode_v,
                         input logic [7:0] lvl, input logic [6:0] exp_lp,
                         input logic [7:0] exp_st);
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h03);
    wr(2'd1, mode_v);
    wr(2'd2, lvl);
    pulse_sleep();
    check("R6 core gated first", {1'b0, outs()}, {1'b0, O_WAIT});
    rd(2'd3, d); check("R6 status stop", d, 8'h02);
    repeat (6) @(negedge clk);
    stop_ack = 4'b0111;
    repeat (4) @(negedge clk);
    check("R7 waits for all acks", {1'b0, outs()}, {1'b0, O_WAIT});
    stop_ack = 4'hF;
    @(posedge clk);
    @(negedge clk);
    check(req, {1'b0, outs()}, {1'b0, exp_lp});
    rd(2'd3, d); check({req, " status"}, d, exp_st);
    @(negedge clk);
    wake = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake = 1'b0;
    check("R12 wake step one", {1'b0, outs()}, {1'b0, O_WAIT});
    @(posedge clk);
    @(negedge clk);
    check("R12 wake step two", {1'b0, outs()}, {1'b0, O_RUN});
    rd(2'd3, d); check("R12 status run", d, 8'h01);
    stop_ack = '0;
  endtask

  task automatic t_abort();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h02);
    pulse_sleep();
    stop_ack = 4'b1011;
    @(negedge clk);
    wake = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake = 1'b0;
    check("R13 abort outputs", {1'b0, outs()}, {1'b0, O_RUN});
    rd(2'd3, d); check("R13 status run", d, 8'h01);
    stop_ack = '0;
  endtask

  initial begin
    t_reset();
    t_prot_once();
    t_ctrl_guard();
    t_level();
    t_run_sleep();
    t_cycle("R11 stop mode", 8'h01, 8'h01, O_STOP, 8'h02);
    t_cycle("R8 vll level 3", 8'h02, 8'h03, O_V3, 8'h04);
    t_cycle("R9 vll level 2", 8'h02, 8'h02, O_V2, 8'h04);
    t_cycle("R10 vll level 1", 8'h02, 8'h01, O_V1, 8'h04);
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule